// File: doc/BRIEF.md
# Change-of-state input interrupt detector

The block watches a bank of 32 digital inputs and raises a level interrupt when a programmed change-of-state condition is met on the lower 16 channels. Each input passes through a two-flop synchroniser. A registered copy of the previous sample is kept so that edges can be found. The upper 16 channels can be read but never cause an interrupt.

Two 16-bit mask registers pick the channels that take part. The "high" mask selects rising edges or high levels, and the "low" mask selects falling edges or low levels. A control register enables detection and selects one of two combining modes. In edge mode, the interrupt fires when any selected channel sees its selected edge. In level mode, it fires only when every selected channel is at its selected level at the same time. After a level-mode firing, some selected input must change level before the logic can fire again. A status register records the channels that caused each event and is cleared when it is read.

Software uses a simple word-addressed register port. Reads return data one cycle after the request. A host can save the control value, write zero to pause detection, and later write the saved value back. All configuration is kept while detection is paused.

Top module: `cos_irq_detector`

## Requirements
- R1: After reset the irq output is 0, and the control, status and both mask registers read as 0.
- R2: A read of address 0 returns all 32 inputs after synchronisation. A value applied to the inputs is visible there within 4 clock cycles.
- R3: Control register (address 3) bit 0 enables detection and bit 1 selects the mode: 0 for edge (OR) and 1 for level (AND). In edge mode, a rising edge on a channel set in the high mask (address 1) sets that channel's bit in the status register (address 4), and irq rises.
- R4: A read of status returns the accumulated event bits and clears them in the same cycle. irq then falls unless a new event arrives.
- R5: In edge mode, a falling edge on a channel set in the low mask (address 2) sets that channel's status bit.
- R6: Only mask bits 15:0 can be written, and bits 31:16 always read back as 0. Activity on inputs 16 to 31 never causes an event.
- R7: In level mode, an event occurs only when every channel selected in either mask is at its level at the same time: high for the high mask, low for the low mask. The status bits of all selected channels are then set. A partial match causes no event.
- R8: After a level-mode event, no further event occurs while the inputs hold still. A level change on a selected channel re-arms the logic.
- R9: While the enable bit is 0, no status bit is set, and the mask values are kept. Writing the saved control value back resumes detection.
- R10: A channel set in both masks reacts to either edge in edge mode. In level mode it is treated as a high-level channel.
- R11: irq is 1 exactly while the enable bit is 1 and at least one status bit is set. Status bits held while detection is disabled stay readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 32 | Asynchronous digital inputs |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address: 0 inputs, 1 high mask, 2 low mask, 3 control, 4 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| irq | output | 1 | Level interrupt request |

## Verification
The bench checks that a level-mode event fires only once while the inputs hold still. It then drops one selected input and raises it again, and checks that a second event follows. A design that skipped the re-arm would either repeat the interrupt constantly or never fire again. The bench also toggles inputs above channel 15 with every mask bit written, and toggles selected inputs while detection is paused. A design with wide masks, or one that ignores the enable bit, would set status in either case. The bench also covers a channel set in both masks. Here a design that required a channel to be both high and low would never fire in level mode, and one that picked only one edge would miss the other in edge mode.

// File: rtl/cos_irq_detector.sv
module cos_irq_detector #(
  parameter int NCH  = 32,
  parameter int NIRQ = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [31:0]    din,
  input  logic           bus_sel,
  input  logic           bus_wr,
  input  logic [2:0]     bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  output logic           irq
);
  localparam int PAD = 32 - NIRQ;
  localparam int IPAD = 32 - NCH;

  logic [NCH-1:0]  s1, s2, prev;
  logic [NIRQ-1:0] m_hi, m_lo, status;
  logic            en, and_mode, armed;

  wire [NIRQ-1:0] cur    = s2[NIRQ-1:0];
  wire [NIRQ-1:0] old    = prev[NIRQ-1:0];
  wire [NIRQ-1:0] sel_ch = m_hi | m_lo;
  wire [NIRQ-1:0] edge_hit = (cur & ~old & m_hi) | (~cur & old & m_lo);
  wire [NIRQ-1:0] lvl_ok   = (m_hi & cur) | (m_lo & ~m_hi & ~cur);
  wire all_met    = (|sel_ch) && ((lvl_ok | ~sel_ch) == {NIRQ{1'b1}});
  wire lvl_change = |((cur ^ old) & sel_ch);
  wire and_fire   = en && and_mode && armed && all_met;
  wire [NIRQ-1:0] new_bits = !en ? '0 :
                             and_mode ? (and_fire ? sel_ch : '0) : edge_hit;

  wire rd   = bus_sel && !bus_wr;
  wire wr   = bus_sel && bus_wr;
  wire rd_st = rd && bus_addr == 3'd4;

  assign irq = en && (|status);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; prev <= '0;
    end else begin
      s1   <= din[NCH-1:0];
      s2   <= s1;
      prev <= s2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_hi <= '0; m_lo <= '0; en <= 1'b0; and_mode <= 1'b0;
    end else if (wr) begin
      case (bus_addr)
        3'd1: m_hi <= bus_wdata[NIRQ-1:0];
        3'd2: m_lo <= bus_wdata[NIRQ-1:0];
        3'd3: begin en <= bus_wdata[0]; and_mode <= bus_wdata[1]; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0;
      armed  <= 1'b1;
    end else begin
      status <= (rd_st ? '0 : status) | new_bits;
      if (and_fire)        armed <= 1'b0;
      else if (lvl_change) armed <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else if (rd) begin
      case (bus_addr)
        3'd0:    bus_rdata <= {{IPAD{1'b0}}, s2};
        3'd1:    bus_rdata <= {{PAD{1'b0}}, m_hi};
        3'd2:    bus_rdata <= {{PAD{1'b0}}, m_lo};
        3'd3:    bus_rdata <= {30'd0, and_mode, en};
        3'd4:    bus_rdata <= {{PAD{1'b0}}, status};
        default: bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/cos_irq_detector_chk.sv
module cos_irq_detector_chk #(
  parameter int NIRQ = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            irq,
  input logic            en,
  input logic [NIRQ-1:0] status,
  input logic            bus_sel,
  input logic            bus_wr,
  input logic [2:0]      bus_addr,
  input logic [31:0]     bus_rdata
);
  assert_read_returns_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == 3'd4) |=> (bus_rdata[NIRQ-1:0] == $past(status)));

  assert_mask_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && (bus_addr == 3'd1 || bus_addr == 3'd2)) |=> (bus_rdata[31:NIRQ] == '0));

  assert_paused_no_new_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ((status & ~$past(status)) == '0));

  assert_irq_rise_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(bus_sel && bus_wr && bus_addr == 3'd3) || (status != $past(status))));
endmodule

bind cos_irq_detector cos_irq_detector_chk #(.NIRQ(NIRQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .en(en), .status(status),
  .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_rdata(bus_rdata)
);

// File: tb/cos_irq_detector_test.sv
module cos_irq_detector_test;
  logic clk = 0, rst_n = 0;
  logic [31:0] din = '0;
  logic bus_sel = 0, bus_wr = 0;
  logic [2:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq;
  int checks = 0, fails = 0;
  logic rd_flag = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  cos_irq_detector uut (.clk, .rst_n, .din, .bus_sel, .bus_wr, .bus_addr,
                        .bus_wdata, .bus_rdata, .irq);

  always @(posedge clk) rd_flag <= bus_sel && !bus_wr;

  always @(negedge clk) if (rd_flag && exp_q.size() > 0) begin
    logic [31:0] e;
    string t;
    e = exp_q.pop_front();
    t = tag_q.pop_front();
    checks++;
    if (bus_rdata !== e) begin
      fails++;
      $display("FAIL %s: rdata=%h expected=%h", t, bus_rdata, e);
    end
  end

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic [2:0] a, input logic [31:0] e, input string t);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); bus_sel = 0;
  endtask

  task automatic set_din(input logic [31:0] v);
    @(negedge clk); din = v;
    repeat (5) @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    checks++;
    if (irq !== e) begin
      fails++;
      $display("FAIL %s: irq=%b expected=%b", t, irq, e);
    end
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog: timeout actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk_irq(0, "R1 irq after reset");
    bus_read(3, 0, "R1 control reset");
    bus_read(4, 0, "R1 status reset");
    bus_read(1, 0, "R1 high mask reset");
    bus_read(2, 0, "R1 low mask reset");

    set_din(32'hA5C3_0F18);
    bus_read(0, 32'hA5C3_0F18, "R2 input readback");
    set_din(32'h0);
    bus_read(0, 32'h0, "R2 input readback zero");

    bus_write(1, 32'h0000_0008);
    bus_write(3, 32'h1);
    chk_irq(0, "R3 no event before edge");
    set_din(32'h0000_0008);
    chk_irq(1, "R3 irq on rising edge");
    bus_read(4, 32'h0000_0008, "R3 status rising channel");
    chk_irq(0, "R4 irq drops after status read");
    bus_read(4, 0, "R4 status cleared by read");

    bus_write(2, 32'h0000_0020);
    set_din(32'h0000_0028);
    chk_irq(0, "R5 rising on low-mask channel ignored");
    set_din(32'h0000_0008);
    bus_read(4, 32'h0000_0020, "R5 falling edge status");

    bus_write(1, 32'hFFFF_0000);
    bus_write(2, 32'hFFFF_0000);
    bus_read(1, 0, "R6 high mask upper bits");
    bus_read(2, 0, "R6 low mask upper bits");
    set_din(32'h5A5A_0008);
    set_din(32'h0000_0008);
    chk_irq(0, "R6 upper inputs never fire");
    bus_read(4, 0, "R6 status untouched");

    bus_write(3, 32'h0);
    set_din(32'h0);
    bus_write(1, 32'h0000_0001);
    bus_write(2, 32'h0000_0002);
    bus_write(3, 32'h3);
    chk_irq(0, "R7 partial match no event");
    set_din(32'h0000_0003);
    chk_irq(0, "R7 ch1 high breaks match");
    set_din(32'h0000_0001);
    chk_irq(1, "R7 all levels met");
    bus_read(4, 32'h0000_0003, "R7 status selected channels");
    repeat (6) @(negedge clk);
    chk_irq(0, "R8 no refire while held");
    set_din(32'h0);
    set_din(32'h0000_0001);
    chk_irq(1, "R8 refire after level change");
    bus_read(4, 32'h0000_0003, "R8 status after rearm");

    bus_write(3, 32'h0);
    bus_write(1, 32'h0000_0100);
    bus_write(2, 32'h0);
    set_din(32'h0000_0100);
    set_din(32'h0);
    chk_irq(0, "R9 no irq while disabled");
    bus_read(4, 0, "R9 no status while disabled");
    bus_read(1, 32'h0000_0100, "R9 mask kept");
    bus_write(3, 32'h1);
    bus_read(3, 32'h1, "R9 control restored");
    set_din(32'h0000_0100);
    bus_read(4, 32'h0000_0100, "R9 resumes after restore");

    bus_write(1, 32'h0000_0004);
    bus_write(2, 32'h0000_0004);
    set_din(32'h0000_0004);
    bus_read(4, 32'h0000_0004, "R10 both masks rising");
    set_din(32'h0);
    bus_read(4, 32'h0000_0004, "R10 both masks falling");
    bus_write(3, 32'h3);
    chk_irq(0, "R10 level low not met");
    set_din(32'h0000_0004);
    bus_read(4, 32'h0000_0004, "R10 both masks treated high");

    bus_write(3, 32'h1);
    bus_write(1, 32'h0000_0040);
    bus_write(2, 32'h0);
    set_din(32'h0000_0040);
    chk_irq(1, "R11 irq with status and enable");
    bus_write(3, 32'h0);
    chk_irq(0, "R11 irq low when disabled");
    bus_read(4, 32'h0000_0040, "R11 held status readable");

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule